// File: doc/BRIEF.md
# Spread-Spectrum Triangular Modulation Sequencer

This block generates the digital frequency-offset profile that steers a spread-spectrum clock. It counts reference clock cycles to form a modulation period whose nominal length is 532 × (L+1) cycles, where L is a 3-bit period divider. Across each period it walks a signed offset code up from zero to a positive peak, down through zero to the negative peak, and back to zero. The peak comes from a 4-bit rate code. A downstream DAC or fractional divider reads the offset word. The zero-crossing strobe marks the instants at which the offset is exactly zero.

The period is deliberately not constant, so that the modulation tone is spread. Periods come in pairs: the first is lengthened and the second is shortened by the same amount, which a 4-bit LFSR picks. The long-term average therefore stays exactly at the nominal length. Modulation is suppressed when the enable input is low, when the locked-loop-only mode is selected, or when the output divider is fed from the raw reference. All configuration is sampled only at period boundaries, so the offset never jumps.

Top module: `ssc_tri_mod`

## Requirements
- R1: While reset is held, and after its release until the first period boundary, `freq_offset` is 0 and `zero_cross` is 0.
- R2: The first period after reset lasts 532 cycles. The periods after it come in pairs: 532·(L+1) + d, then 532·(L+1) − d, with d = 5·v·(L+1). Here v is the 4-bit LFSR state, which starts at 1 and advances after each pair by v ← {v[2:0], v[3]^v[2]}. L is sampled at the boundary that starts the period.
- R3: Every period lies between 448·(L+1) and 616·(L+1) cycles, and each lengthened/shortened pair sums to exactly 1064·(L+1) cycles.
- R4: The peak offset is PK_SCALE (default 4) LSBs per 0.125 % unit. Codes 1 to 8 give 1, 2, 4, 6, 8, 10, 12 and 14 units. Code 0 and codes 9 to 15 give a peak of 0.
- R5: The peak is forced to 0 when `mod_enable` is 0, when `lock_mode` is 1, or when `ref_bypass` is 1, whatever the rate code.
- R6: Within a period the offset starts at 0, rises to +peak, falls to −peak and returns to 0 in the last cycle of the period. It changes by at most one LSB per cycle.
- R7: `zero_cross` is high for one cycle each time the offset becomes 0: at the mid-period crossing and at each period boundary. That is two pulses per period when the peak is non-zero, and one pulse when it is zero.
- R8: Changes of the rate code, gating inputs or L made in the middle of a period have no effect until the next period boundary. In particular, disabling modulation lets the current triangle complete, and the offset then stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; every cycle counts toward the period |
| rst_n | input | 1 | Active-low synchronous reset |
| period_div | input | 3 | Period divider L; nominal period 532·(L+1) cycles |
| rate_sel | input | 4 | Peak deviation code |
| mod_enable | input | 1 | 1 applies the configured rate, 0 forces no modulation |
| lock_mode | input | 1 | 1 selects the locked-loop-only mode (no modulation) |
| ref_bypass | input | 1 | 1 when the output divider runs from the raw reference (no modulation) |
| freq_offset | output | 8 | Signed triangular offset code |
| zero_cross | output | 1 | One-cycle pulse when the offset becomes zero |

## Verification
The bench measures the length of every period between boundary pulses and compares it with an independent model of the paired LFSR dither. A sign or sequencing error in the pairing shows up as a wrong length or as a broken 1064·(L+1) pair sum. For each configuration it records the extreme offsets, the largest per-cycle jump and the pulse count. A wrongly paced walk would stop short of its peak, overshoot it, or miss the return to zero at the boundary. A mapping or gating fault gives the wrong peak. Rate and enable changes are injected mid-period: a design that samples them early would truncate the running triangle, and one that ignores them would keep modulating.

// File: rtl/ssc_tri_pkg.sv
package ssc_tri_pkg;

   localparam int unsigned RATE_W    = 4;
   localparam int unsigned MAX_UNITS = 14;

   // deviation in 0.125 % units for each rate code
   function automatic logic [3:0] rate_units(input logic [RATE_W-1:0] code);
      logic [3:0] u;
      case (code)
         4'd1:    u = 4'd1;
         4'd2:    u = 4'd2;
         4'd3:    u = 4'd4;
         4'd4:    u = 4'd6;
         4'd5:    u = 4'd8;
         4'd6:    u = 4'd10;
         4'd7:    u = 4'd12;
         4'd8:    u = 4'd14;
         default: u = 4'd0;
      endcase
      return u;
   endfunction

endpackage

// File: rtl/ssc_period_gen.sv
module ssc_period_gen #(
   parameter int unsigned BASE   = 532,
   parameter int unsigned SPAN   = 84,
   parameter int unsigned DSTEP  = 5,
   parameter int unsigned LDIV_W = 3,
   parameter int unsigned LFSR_W = 4,
   parameter int unsigned CNT_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LDIV_W-1:0] div,
   output logic              bound,
   output logic [CNT_W-1:0]  plen
);

   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  lmul;
   logic [CNT_W-1:0]  mult;
   logic [CNT_W-1:0]  base_len;
   logic [CNT_W-1:0]  dev;
   logic              half;
   logic [LFSR_W-1:0] lfsr;
   logic [LFSR_W-1:0] lfsr_nxt;
   logic              fb;

   generate
      if (LFSR_W == 3) begin : g_tap3
         assign fb = lfsr[2] ^ lfsr[1];
      end else if (LFSR_W == 4) begin : g_tap4
         assign fb = lfsr[3] ^ lfsr[2];
      end else begin : g_tap5
         assign fb = lfsr[4] ^ lfsr[2];
      end
   endgenerate

   assign lfsr_nxt = {lfsr[LFSR_W-2:0], fb};
   assign mult     = CNT_W'(div) + CNT_W'(1);
   assign base_len = CNT_W'(BASE) * mult;
   assign dev      = CNT_W'(lfsr) * CNT_W'(DSTEP) * mult;
   assign bound    = (cnt == plen - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         plen <= CNT_W'(BASE);
         lmul <= CNT_W'(1);
         half <= 1'b0;
         lfsr <= LFSR_W'(1);
      end else if (bound) begin
         cnt  <= '0;
         lmul <= mult;
         half <= ~half;
         if (half) begin
            plen <= base_len - dev;
            lfsr <= lfsr_nxt;
         end else begin
            plen <= base_len + dev;
         end
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   logic [CNT_W-1:0] lo_len;
   logic [CNT_W-1:0] hi_len;
   assign lo_len = CNT_W'(BASE - SPAN) * lmul;
   assign hi_len = CNT_W'(BASE + SPAN) * lmul;

   // R3
   plen_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (plen >= lo_len) && (plen <= hi_len));

   // R2
   cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < plen);

endmodule

// File: rtl/ssc_tri_walker.sv
module ssc_tri_walker #(
   parameter int unsigned OFS_W = 8,
   parameter int unsigned CNT_W = 13
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bound,
   input  logic [CNT_W-1:0]        plen,
   input  logic [OFS_W-2:0]        peak_req,
   output logic signed [OFS_W-1:0] offset,
   output logic                    zstrobe
);

   localparam logic signed [OFS_W-1:0] ONE = OFS_W'(1);

   logic [OFS_W-2:0]        pk;
   logic signed [OFS_W-1:0] pk_pos;
   logic signed [OFS_W-1:0] pk_neg;
   logic [CNT_W-1:0]        acc;
   logic [CNT_W-1:0]        stride;
   logic [CNT_W:0]          sum;
   logic                    step;
   logic                    dir_up;
   logic signed [OFS_W-1:0] next_off;

   assign pk_pos   = $signed({1'b0, pk});
   assign pk_neg   = -pk_pos;
   assign stride   = CNT_W'(pk) << 2;
   assign sum      = {1'b0, acc} + {1'b0, stride};
   assign step     = (sum >= {1'b0, plen});
   assign next_off = !step ? offset : (dir_up ? offset + ONE : offset - ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pk      <= '0;
         acc     <= '0;
         dir_up  <= 1'b1;
         offset  <= '0;
         zstrobe <= 1'b0;
      end else begin
         offset  <= next_off;
         zstrobe <= bound || (step && (next_off == '0));
         if (bound) begin
            acc    <= '0;
            pk     <= peak_req;
            dir_up <= 1'b1;
         end else begin
            acc <= step ? CNT_W'(sum - {1'b0, plen}) : CNT_W'(sum);
            if (step && dir_up && (next_off == pk_pos)) begin
               dir_up <= 1'b0;
            end else if (step && !dir_up && (next_off == pk_neg)) begin
               dir_up <= 1'b1;
            end
         end
      end
   end

   // R6
   step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (offset == $past(offset)) || (offset == $past(offset) + ONE) ||
      (offset == $past(offset) - ONE));

   // R6
   within_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (offset <= pk_pos) && (offset >= pk_neg));

   // R6
   bound_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bound |=> (offset == '0));

   // R7
   strobe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zstrobe |-> (offset == '0));

endmodule

// File: rtl/ssc_tri_mod.sv
module ssc_tri_mod
   import ssc_tri_pkg::*;
#(
   parameter int unsigned BASE     = 532,
   parameter int unsigned SPAN     = 84,
   parameter int unsigned DSTEP    = 5,
   parameter int unsigned LDIV_W   = 3,
   parameter int unsigned LFSR_W   = 4,
   parameter int unsigned PK_SCALE = 4,
   parameter int unsigned OFS_W    = 8
) (
   input  logic                    clk_ref,
   input  logic                    rst_n,
   input  logic [LDIV_W-1:0]       period_div,
   input  logic [RATE_W-1:0]       rate_sel,
   input  logic                    mod_enable,
   input  logic                    lock_mode,
   input  logic                    ref_bypass,
   output logic signed [OFS_W-1:0] freq_offset,
   output logic                    zero_cross
);

   localparam int unsigned MAX_MUL = 1 << LDIV_W;
   localparam int unsigned CNT_W   = $clog2((BASE + SPAN) * MAX_MUL + 1);
   localparam int unsigned PK_W    = OFS_W - 1;
   localparam int unsigned MAX_PK  = MAX_UNITS * PK_SCALE;

   initial begin
      peak_fits_chk: assert (MAX_PK < (1 << PK_W))
         else $error("offset word too narrow for the largest peak");
      pace_chk: assert (4 * MAX_PK <= BASE - SPAN)
         else $error("walk would need more than one step per cycle");
      dither_chk: assert (DSTEP * ((1 << LFSR_W) - 1) <= SPAN)
         else $error("dither exceeds the permitted period span");
      lfsr_w_chk: assert (LFSR_W >= 3 && LFSR_W <= 5)
         else $error("unsupported LFSR width");
   end

   logic             gate_off;
   logic [PK_W-1:0]  peak_req;
   logic             bound;
   logic [CNT_W-1:0] plen;

   assign gate_off = !mod_enable || lock_mode || ref_bypass;
   assign peak_req = gate_off ? '0 : PK_W'(rate_units(rate_sel)) * PK_W'(PK_SCALE);

   ssc_period_gen #(
      .BASE(BASE), .SPAN(SPAN), .DSTEP(DSTEP),
      .LDIV_W(LDIV_W), .LFSR_W(LFSR_W), .CNT_W(CNT_W)
   ) u_period (
      .clk  (clk_ref),
      .rst_n(rst_n),
      .div  (period_div),
      .bound(bound),
      .plen (plen)
   );

   ssc_tri_walker #(
      .OFS_W(OFS_W), .CNT_W(CNT_W)
   ) u_walk (
      .clk     (clk_ref),
      .rst_n   (rst_n),
      .bound   (bound),
      .plen    (plen),
      .peak_req(peak_req),
      .offset  (freq_offset),
      .zstrobe (zero_cross)
   );

endmodule

// File: tb/tb_ssc_tri_mod.sv
module tb_ssc_tri_mod;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 10;

   // {L[2:0], code[3:0], en, lock, bypass, expected peak[5:0]}
   localparam logic [15:0] VEC [NV] = '{
      {3'd0, 4'd1,  1'b1, 1'b0, 1'b0, 6'd4},
      {3'd0, 4'd8,  1'b1, 1'b0, 1'b0, 6'd56},
      {3'd3, 4'd4,  1'b1, 1'b0, 1'b0, 6'd24},
      {3'd7, 4'd8,  1'b1, 1'b0, 1'b0, 6'd56},
      {3'd2, 4'd5,  1'b1, 1'b1, 1'b0, 6'd0},
      {3'd1, 4'd6,  1'b1, 1'b0, 1'b1, 6'd0},
      {3'd4, 4'd7,  1'b0, 1'b0, 1'b0, 6'd0},
      {3'd0, 4'd12, 1'b1, 1'b0, 1'b0, 6'd0},
      {3'd5, 4'd3,  1'b1, 1'b0, 1'b0, 6'd16},
      {3'd0, 4'd2,  1'b1, 1'b0, 1'b0, 6'd8}
   };

   logic              clk_ref = 1'b0;
   logic              rst_n = 1'b0;
   logic [2:0]        period_div = '0;
   logic [3:0]        rate_sel = '0;
   logic              mod_enable = 1'b0;
   logic              lock_mode = 1'b0;
   logic              ref_bypass = 1'b0;
   logic signed [7:0] freq_offset;
   logic              zero_cross;

   int n_chk = 0;
   int n_fail = 0;
   int want_pk = 0;
   int want_l = 0;

   // monitor state
   int ev = 0;
   int m_len, m_max, m_min, m_nstr, last_off;
   bit m_jump, m_first, m_h;
   logic [3:0] m_lfsr;
   int exp_len, exp_pk, exp_lm;
   bit exp_plus;
   int rec_len, rec_max, rec_min, rec_nstr, rec_exp_len, rec_exp_pk, rec_exp_lm;
   bit rec_jump, rec_first, rec_plus;

   ssc_tri_mod dut (
      .clk_ref(clk_ref), .rst_n(rst_n), .period_div(period_div),
      .rate_sel(rate_sel), .mod_enable(mod_enable), .lock_mode(lock_mode),
      .ref_bypass(ref_bypass), .freq_offset(freq_offset), .zero_cross(zero_cross)
   );

   always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

   always @(negedge clk_ref) begin
      int o, d, lm, v;
      o = int'(freq_offset);
      if (!rst_n) begin
         m_len = 0; m_max = 0; m_min = 0; m_nstr = 0; last_off = 0;
         m_jump = 0; m_first = 1; m_h = 0; m_lfsr = 4'd1;
         exp_len = 532; exp_pk = 0; exp_lm = 1; exp_plus = 0;
      end else begin
         d = o - last_off;
         if (d > 1 || d < -1) m_jump = 1;
         if (zero_cross && last_off <= 0) begin
            rec_len = m_len; rec_max = m_max; rec_min = m_min;
            rec_nstr = m_nstr + 1; rec_jump = m_jump; rec_first = m_first;
            rec_exp_len = exp_len; rec_exp_pk = exp_pk; rec_exp_lm = exp_lm;
            rec_plus = exp_plus;
            m_first = 0;
            lm = want_l + 1;
            v = int'(m_lfsr);
            if (!m_h) begin
               exp_len = 532 * lm + 5 * v * lm; m_h = 1; exp_plus = 1;
            end else begin
               exp_len = 532 * lm - 5 * v * lm; m_h = 0; exp_plus = 0;
               m_lfsr = {m_lfsr[2:0], m_lfsr[3] ^ m_lfsr[2]};
            end
            exp_pk = want_pk; exp_lm = lm;
            m_len = 1; m_max = 0; m_min = 0; m_nstr = 0; m_jump = 0;
            ev++;
         end else begin
            m_len++;
            if (o > m_max) m_max = o;
            if (o < m_min) m_min = o;
            if (zero_cross) m_nstr++;
         end
         last_off = o;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wait_ev();
      int e0 = ev;
      while (ev == e0) @(posedge clk_ref);
   endtask

   task automatic check_period(input string tag);
      if (!rec_first) begin
         chk(rec_len == rec_exp_len, "R2 period length", rec_len, rec_exp_len);
         chk(rec_len >= 448 * rec_exp_lm && rec_len <= 616 * rec_exp_lm,
             "R3 period bounds", rec_len, 532 * rec_exp_lm);
      end
      chk(rec_max == rec_exp_pk, {tag, " positive peak"}, rec_max, rec_exp_pk);
      chk(rec_min == -rec_exp_pk, {tag, " negative peak"}, rec_min, -rec_exp_pk);
      chk(rec_nstr == ((rec_exp_pk != 0) ? 2 : 1), "R7 zero crossings",
          rec_nstr, (rec_exp_pk != 0) ? 2 : 1);
      chk(!rec_jump, "R6 step size", int'(rec_jump), 0);
   endtask

   task automatic apply(input logic [15:0] v);
      period_div = v[15:13];
      rate_sel   = v[12:9];
      mod_enable = v[8];
      lock_mode  = v[7];
      ref_bypass = v[6];
      want_l     = int'(v[15:13]);
      want_pk    = int'(v[5:0]);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      string prev_tag;
      int s;
      bit done;
      // R1 during reset
      repeat (4) @(negedge clk_ref);
      chk(freq_offset == 0, "R1 offset in reset", int'(freq_offset), 0);
      chk(zero_cross == 1'b0, "R1 strobe in reset", int'(zero_cross), 0);
      @(posedge clk_ref);
      #1 rst_n = 1'b1;
      repeat (100) @(negedge clk_ref);
      chk(freq_offset == 0, "R1 offset after reset", int'(freq_offset), 0);
      chk(zero_cross == 1'b0, "R1 strobe after reset", int'(zero_cross), 0);

      prev_tag = "R1";
      for (int i = 0; i < NV; i++) begin
         string tag;
         logic [15:0] v;
         v = VEC[i];
         tag = (v[8] && !v[7] && !v[6]) ? "R4" : "R5";
         apply(v);
         wait_ev();
         check_period(prev_tag);
         wait_ev();
         check_period(tag);
         prev_tag = tag;
      end

      // R8: disable mid-period, the running triangle completes
      apply({3'd0, 4'd8, 1'b1, 1'b0, 1'b0, 6'd56});
      wait_ev();
      check_period(prev_tag);
      repeat (150) @(posedge clk_ref);
      #1;
      mod_enable = 1'b0;
      rate_sel   = 4'd1;
      period_div = 3'd1;
      want_pk    = 0;
      want_l     = 1;
      wait_ev();
      check_period("R8");
      wait_ev();
      check_period("R8");

      // R3: a lengthened/shortened pair sums to 1064*(L+1)
      apply({3'd7, 4'd0, 1'b1, 1'b0, 1'b0, 6'd0});
      wait_ev();
      wait_ev();
      done = 0;
      for (int k = 0; k < 3 && !done; k++) begin
         wait_ev();
         if (rec_plus) begin
            s = rec_len;
            wait_ev();
            s += rec_len;
            chk(s == 1064 * 8, "R3 pair sum", s, 1064 * 8);
            done = 1;
         end
      end
      chk(done, "R3 pair found", int'(done), 1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule